// File: doc/BRIEF.md
# Parallel Flash Asynchronous Read Controller

This block sits between a host and a 16-bit parallel NOR-style flash and performs asynchronous reads only. The host hands over a word address, a burst length and two mode bits on a valid/ready handshake. The controller then drives the flash control pins through one or more read cycles. For each word it waits the number of clock cycles needed to meet both access-time limits, captures the data bus, and returns the word on a one-cycle data-valid pulse. A last flag marks the final word.

Two read styles are available. In single-word mode every word is a complete cycle: enable, address setup, output enable, capture, then recovery. In page mode the words that share a 4-word aligned group are read back to back, with chip enable and output enable held low and only address bits [1:0] stepping, after a shorter page delay. Crossing into the next group starts a new full cycle.

The address-valid strobe can pulse high after setup to latch the address, or stay low for the whole cycle; the request picks which. The flash reset pin is held low for a set number of cycles after controller reset and after a host reset request. The flash clock and write enable pins are held high, and the wait input is ignored.

Top module: `pflash_async_rd`

## Requirements
- R1: After the synchronous reset `rst` is released, `fl_rst_n` stays low for exactly T_RST cycles. While `rst` is high: `fl_ce_n`, `fl_oe_n` and `fl_adv_n` are 1, `rd_valid` is 0 and `req_ready` is 0.
- R2: `rst_req` is sampled while idle. It drives `fl_rst_n` low for exactly T_RST cycles. Chip enable and output enable stay high (1) whenever `fl_rst_n` is low.
- R3: `fl_we_n` and `fl_clk` are 1 in every cycle.
- R4: In the cycle after a request is accepted, `fl_ce_n` is 0 and `fl_addr` holds the word address. `fl_oe_n` falls exactly T_SETUP cycles after `fl_ce_n` falls. `fl_oe_n` is never 0 while `fl_ce_n` is 1.
- R5: While `fl_ce_n` is 0 and `fl_oe_n` is 1, `fl_adv_n` is 0. While both are 0, `fl_adv_n` equals `req_adv_latch` of the current request (1 = pulse high to latch, 0 = hold low).
- R6: The first word of a full cycle is captured T_AVQV cycles after the address is presented with chip enable low, and T_GLQV cycles after output enable falls, whichever is later. `rd_valid` rises max(T_AVQV, T_SETUP+T_GLQV)+2 cycles after the accept cycle.
- R7: With `req_page`=1, a next word whose address bits [1:0] are not 00 stays in the open page. Only bits [1:0] of `fl_addr` change, chip enable and output enable stay low, and `rd_valid` pulses exactly T_APA+1 cycles after the previous one.
- R8: In single-word mode, or when a page burst crosses a 4-word boundary, chip enable and output enable go high for exactly T_REC cycles before the next word's full cycle. `fl_ce_n` is never high for fewer than T_REC cycles between two low periods.
- R9: `req_len` is the word count minus one. A request yields exactly `req_len`+1 `rd_valid` pulses for consecutive addresses starting at `req_addr`, and `rd_last` is 1 only on the final pulse.
- R10: `fl_wait` has no effect: data and timing are identical whatever it does.
- R11: `rd_data` always carries the word at the addressed location, never a value taken while the bus is undriven or not yet valid.
- R12: `req_ready` is 0 from acceptance until the last word. It returns to 1 exactly T_REC cycles after the `rd_last` pulse. An accepted request makes `fl_ce_n` 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req | input | 1 | Host request to pulse the flash reset pin |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | AW | Starting word address |
| req_len | input | LW | Words to read minus one |
| req_page | input | 1 | 1 = page mode, 0 = single-word mode |
| req_adv_latch | input | 1 | 1 = pulse address-valid high after setup, 0 = hold it low |
| rd_valid | output | 1 | One-cycle pulse with a captured word |
| rd_data | output | DW | Captured word |
| rd_last | output | 1 | Marks the final word of a request |
| fl_clk | output | 1 | Flash clock, held high |
| fl_rst_n | output | 1 | Flash reset, active low |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_adv_n | output | 1 | Flash address-valid strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, held high |
| fl_addr | output | AW | Flash word address |
| fl_dq | input | DW | Flash data bus |
| fl_wait | input | 1 | Flash wait signal, ignored |

## Verification
The hardest case to reach is a page burst that starts in the middle of a group and runs past its end. The controller must then close the page, recover, and reopen at the next group with a full access, all without host action. The bench reaches this with directed bursts at offsets 2 and 3 of a group and at the longest length. Random bursts then mix offsets, lengths and both strobe options. A flash model supplies wrong data whenever either access window is not yet met, and it counts a page-hit shortcut only after a full access inside the same group. Early capture, a wrong window or a missed page boundary therefore shows up as wrong data or wrong pulse spacing.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic [2:0] {
    S_RST    = 3'd0,
    S_IDLE   = 3'd1,
    S_SETUP  = 3'd2,
    S_ACCESS = 3'd3,
    S_PAGE   = 3'd4,
    S_REC    = 3'd5
  } pfr_state_e;
endpackage

// File: rtl/pfr_timer.sv
// Cycle down-counter: loaded on start, done while it sits at zero.
module pfr_timer #(
  parameter int CW   = 8,
  parameter int INIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= CW'(INIT);
    else if (start)      cnt <= load;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pflash_async_rd.sv
module pflash_async_rd
  import pfr_pkg::*;
#(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int LW      = 8,
  parameter int CW      = 8,
  parameter int T_RST   = 16,
  parameter int T_SETUP = 2,
  parameter int T_AVQV  = 9,
  parameter int T_GLQV  = 5,
  parameter int T_APA   = 3,
  parameter int T_REC   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rst_req,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          req_page,
  input  logic          req_adv_latch,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic          fl_clk,
  output logic          fl_rst_n,
  output logic          fl_ce_n,
  output logic          fl_adv_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  input  logic [DW-1:0] fl_dq,
  input  logic          fl_wait
);
  localparam logic [CW-1:0] LD_RST   = CW'(T_RST - 1);
  localparam logic [CW-1:0] LD_SETUP = CW'(T_SETUP - 1);
  localparam logic [CW-1:0] LD_REC   = CW'(T_REC - 1);
  localparam logic [CW-1:0] LD_PAGE  = CW'(T_APA);
  localparam logic [CW-1:0] LD_AVQV  = CW'(T_AVQV);
  localparam logic [CW-1:0] LD_GLQV  = CW'(T_GLQV);

  pfr_state_e    state;
  logic [LW-1:0] rem;
  logic          page_q, latch_q, cont_q;

  logic g_start, g_done, a_start, a_done, o_start, o_done;
  logic [CW-1:0] g_load;
  logic accept, go_rst, take, more, stay_page, setup_go, rec_cont;

  // Wait is ignored in asynchronous modes; only kept so the pin is consumed.
  logic unused_wait;
  assign unused_wait = fl_wait;

  assign fl_clk    = 1'b1;
  assign fl_we_n   = 1'b1;
  assign req_ready = (state == S_IDLE) && !rst_req;

  always_comb begin
    go_rst    = (state == S_IDLE) && rst_req;
    accept    = (state == S_IDLE) && !rst_req && req_valid;
    take      = ((state == S_ACCESS) && a_done && o_done) ||
                ((state == S_PAGE) && g_done);
    more      = (rem != '0);
    stay_page = more && page_q && (fl_addr[1:0] != 2'b11);
    setup_go  = (state == S_SETUP) && g_done;
    rec_cont  = (state == S_REC) && g_done && cont_q;

    g_start = go_rst || accept || take || rec_cont;
    if (go_rst)                  g_load = LD_RST;
    else if (accept || rec_cont) g_load = LD_SETUP;
    else if (stay_page)          g_load = LD_PAGE;
    else                         g_load = LD_REC;

    a_start = accept || rec_cont;
    o_start = setup_go;
  end

  // General sequencing timer: reset hold, setup, page step, recovery.
  pfr_timer #(.CW(CW), .INIT(T_RST - 1)) u_gen_tmr (
    .clk(clk), .rst(rst), .start(g_start), .load(g_load), .done(g_done));

  // Address-path access timer, started when the address is presented.
  pfr_timer #(.CW(CW), .INIT(0)) u_addr_tmr (
    .clk(clk), .rst(rst), .start(a_start), .load(LD_AVQV), .done(a_done));

  // Output-enable-path access timer, started when output enable falls.
  pfr_timer #(.CW(CW), .INIT(0)) u_oe_tmr (
    .clk(clk), .rst(rst), .start(o_start), .load(LD_GLQV), .done(o_done));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_RST;
      fl_rst_n <= 1'b0;
      fl_ce_n  <= 1'b1;
      fl_oe_n  <= 1'b1;
      fl_adv_n <= 1'b1;
      fl_addr  <= '0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_data  <= '0;
      rem      <= '0;
      page_q   <= 1'b0;
      latch_q  <= 1'b0;
      cont_q   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      case (state)
        S_RST: if (g_done) begin
          state    <= S_IDLE;
          fl_rst_n <= 1'b1;
        end
        S_IDLE: begin
          if (go_rst) begin
            state    <= S_RST;
            fl_rst_n <= 1'b0;
          end else if (accept) begin
            state    <= S_SETUP;
            fl_ce_n  <= 1'b0;
            fl_adv_n <= 1'b0;
            fl_addr  <= req_addr;
            rem      <= req_len;
            page_q   <= req_page;
            latch_q  <= req_adv_latch;
          end
        end
        S_SETUP: if (g_done) begin
          state    <= S_ACCESS;
          fl_oe_n  <= 1'b0;
          fl_adv_n <= latch_q;
        end
        S_ACCESS, S_PAGE: if (take) begin
          rd_valid <= 1'b1;
          rd_data  <= fl_dq;
          rd_last  <= !more;
          cont_q   <= more;
          if (more) begin
            rem     <= rem - 1'b1;
            fl_addr <= fl_addr + AW'(1);
          end
          if (stay_page) begin
            state <= S_PAGE;
          end else begin
            state    <= S_REC;
            fl_ce_n  <= 1'b1;
            fl_oe_n  <= 1'b1;
            fl_adv_n <= 1'b1;
          end
        end
        S_REC: if (g_done) begin
          if (cont_q) begin
            state    <= S_SETUP;
            fl_ce_n  <= 1'b0;
            fl_adv_n <= 1'b0;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pfr_chk.sv
module pfr_chk #(
  parameter int T_REC = 2
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic fl_ce_n,
  input logic fl_oe_n,
  input logic fl_rst_n,
  input logic rd_valid,
  input logic rd_last
);
  logic [7:0] hi_run;
  logic       seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= '0;
      seen_q <= 1'b0;
    end else begin
      if (!fl_ce_n)              hi_run <= '0;
      else if (hi_run != 8'hFF)  hi_run <= hi_run + 1'b1;
      if (!fl_ce_n) seen_q <= 1'b1;
    end
  end

  // R4
  oe_under_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> !fl_ce_n);

  // R11
  sample_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!fl_oe_n && !fl_ce_n));

  // R9
  last_is_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> rd_valid);

  // R2
  rst_isolates_chk: assert property (@(posedge clk) disable iff (rst)
    !fl_rst_n |-> (fl_ce_n && fl_oe_n));

  // R12
  accept_starts_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !fl_ce_n);

  // R8
  recovery_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(fl_ce_n) && seen_q) |-> (hi_run >= 8'(T_REC)));
endmodule

bind pflash_async_rd pfr_chk #(.T_REC(T_REC)) u_pfr_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_rst_n(fl_rst_n),
  .rd_valid(rd_valid), .rd_last(rd_last));

// File: tb/test_pflash_async_rd.sv
`timescale 1ns/1ps
module test_pflash_async_rd;
  localparam int AW = 20, DW = 16, LW = 4, CW = 8;
  localparam int T_RST = 5, T_SETUP = 2, T_AVQV = 7, T_GLQV = 3, T_APA = 2, T_REC = 2;
  localparam int M = (T_AVQV > T_SETUP + T_GLQV) ? T_AVQV : T_SETUP + T_GLQV;

  logic clk = 0, rst = 1, rst_req = 0, req_valid = 0, req_page = 0, req_adv_latch = 0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic req_ready, rd_valid, rd_last, fl_clk, fl_rst_n, fl_ce_n, fl_adv_n, fl_oe_n, fl_we_n;
  logic [DW-1:0] rd_data, fl_dq;
  logic [AW-1:0] fl_addr;
  logic fl_wait = 0;

  always #2 clk = ~clk;

  pflash_async_rd #(.AW(AW), .DW(DW), .LW(LW), .CW(CW), .T_RST(T_RST), .T_SETUP(T_SETUP),
    .T_AVQV(T_AVQV), .T_GLQV(T_GLQV), .T_APA(T_APA), .T_REC(T_REC)) i_pflash_async_rd (
    .clk(clk), .rst(rst), .rst_req(rst_req), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_page(req_page), .req_adv_latch(req_adv_latch),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last), .fl_clk(fl_clk),
    .fl_rst_n(fl_rst_n), .fl_ce_n(fl_ce_n), .fl_adv_n(fl_adv_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_dq(fl_dq), .fl_wait(fl_wait));

  int n_chk = 0, n_bad = 0;
  bit finished = 0, noise = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input logic [AW-1:0] a);
    logic [31:0] t;
    t = {12'b0, a} * 32'h0001_9E37;
    return t[15:0] ^ t[31:16] ^ 16'h3C5A;
  endfunction

  // ---------------- flash model ----------------
  int  a_age = 0, o_age = 0;
  bit  m_hit = 0, page_ok = 0, m_valid = 0, mp_ce_n = 1, mp_oe_n = 1;
  logic [AW-1:0] mp_addr = '0;
  assign fl_dq = (fl_ce_n || fl_oe_n) ? 16'hFFFF : (m_valid ? word_of(fl_addr) : 16'hDEAD);

  always @(negedge clk) begin : model
    bit chg;
    chg = (fl_addr != mp_addr);
    if (fl_ce_n || mp_ce_n || chg) a_age = 0; else if (a_age < 1000) a_age++;
    if (fl_oe_n || mp_oe_n) o_age = 0; else if (o_age < 1000) o_age++;
    if (fl_ce_n || fl_oe_n) m_hit = 0;
    else if (!mp_ce_n && chg) m_hit = page_ok && (fl_addr[AW-1:2] == mp_addr[AW-1:2]);
    m_valid = !fl_ce_n && !fl_oe_n && (a_age >= (m_hit ? T_APA : T_AVQV)) && (o_age >= T_GLQV);
    page_ok = (fl_ce_n || fl_oe_n) ? 0 : (page_ok || m_valid);
    mp_ce_n = fl_ce_n; mp_oe_n = fl_oe_n; mp_addr = fl_addr;
  end

  always @(posedge clk) begin
    #1 fl_wait = noise ? 1'($urandom % 2) : 1'b0;
  end

  // ---------------- monitor ----------------
  int cyc = 0, acc = 0, pv = 0, wi = 0, ce_fall = 0, ce_hi = 0, rst_run = 0, last_cyc = -1;
  int v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r7 = 0, v_r9 = 0, v_r12 = 0;
  bit busy = 0, seen_ce = 0, first_rst = 1, p_ce_n = 1, p_oe_n = 1, p_rst_n = 0;
  bit cur_page = 0, cur_latch = 0;
  logic [AW-1:0] cur_addr = '0, p_addr = '0;
  int cur_len = 0;

  always @(negedge clk) begin : mon
    cyc++;
    if (rst) begin
      busy = 0; rst_run = 0; p_ce_n = 1; p_oe_n = 1; p_rst_n = 0;
    end else begin
      if (!(fl_we_n && fl_clk)) v_r3++;
      if (!fl_rst_n && (!fl_ce_n || !fl_oe_n)) v_r2++;
      if (!fl_rst_n) rst_run++;
      else if (!p_rst_n) begin
        chk(rst_run == T_RST, first_rst ? "R1" : "R2", "flash reset low cycles", rst_run, T_RST);
        first_rst = 0; rst_run = 0;
      end
      if (!fl_ce_n && p_ce_n) begin
        ce_fall = cyc;
        if (seen_ce) begin
          chk(ce_hi >= T_REC, "R8", "min chip-enable high gap", ce_hi, T_REC);
          if (busy && wi > 0) chk(ce_hi == T_REC, "R8", "recovery gap in burst", ce_hi, T_REC);
        end
        seen_ce = 1;
      end
      ce_hi = fl_ce_n ? ce_hi + 1 : 0;
      if (!fl_oe_n && p_oe_n)
        chk(cyc - ce_fall == T_SETUP, "R4", "ce fall to oe fall", cyc - ce_fall, T_SETUP);
      if (!fl_oe_n && fl_ce_n) v_r4++;
      if (!fl_ce_n && (fl_adv_n !== (fl_oe_n ? 1'b0 : cur_latch))) v_r5++;
      if (!fl_ce_n && !p_ce_n && fl_addr != p_addr && fl_addr[AW-1:2] != p_addr[AW-1:2]) v_r7++;
      if (busy && req_ready) v_r12++;
      if (req_valid && req_ready) begin
        busy = 1; acc = cyc; wi = 0;
        cur_addr = req_addr; cur_len = int'(req_len); cur_page = req_page; cur_latch = req_adv_latch;
      end
      if (last_cyc >= 0 && cyc == last_cyc + T_REC) begin
        chk(req_ready == 1'b1, "R12", "ready after last + recovery", req_ready, 1);
        last_cyc = -1;
      end else if (last_cyc >= 0 && req_ready) v_r12++;
      if (rd_valid) begin
        if (!busy) v_r9++;
        else begin
          logic [AW-1:0] ea;
          ea = cur_addr + AW'(wi);
          chk(rd_data == word_of(ea), "R11", "captured word", rd_data, word_of(ea));
          chk(rd_last == (wi == cur_len), "R9", "last flag", rd_last, wi == cur_len);
          if (wi == 0)
            chk(cyc - acc == M + 2, noise ? "R10" : "R6", "first word latency", cyc - acc, M + 2);
          else if (cur_page && ea[1:0] != 2'b00)
            chk(cyc - pv == T_APA + 1, "R7", "page word spacing", cyc - pv, T_APA + 1);
          else
            chk(cyc - pv == T_REC + 1 + M, "R8", "full-cycle word spacing", cyc - pv, T_REC + 1 + M);
          pv = cyc; wi++;
          if (rd_last || wi > cur_len) begin busy = 0; last_cyc = cyc; end
        end
      end
      p_ce_n = fl_ce_n; p_oe_n = fl_oe_n; p_rst_n = fl_rst_n; p_addr = fl_addr;
    end
  end

  // ---------------- driver ----------------
  task automatic send(input logic [AW-1:0] a, input int len, input bit pg, input bit lt);
    @(posedge clk); #1;
    req_valid = 1; req_addr = a; req_len = LW'(len); req_page = pg; req_adv_latch = lt;
    forever begin @(negedge clk); if (req_ready) break; end
    @(posedge clk); #1 req_valid = 0;
    do @(negedge clk); while (busy);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!req_ready);
  endtask

  task automatic report();
    chk(v_r2 == 0, "R2", "ce/oe low during flash reset", v_r2, 0);
    chk(v_r3 == 0, "R3", "we/clk not high", v_r3, 0);
    chk(v_r4 == 0, "R4", "oe low without ce", v_r4, 0);
    chk(v_r5 == 0, "R5", "address-valid level errors", v_r5, 0);
    chk(v_r7 == 0, "R7", "upper address change inside page", v_r7, 0);
    chk(v_r9 == 0, "R9", "spurious data pulses", v_r9, 0);
    chk(v_r12 == 0, "R12", "ready while busy", v_r12, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(fl_ce_n && fl_oe_n && fl_adv_n, "R1", "pins idle in reset", {fl_ce_n, fl_oe_n, fl_adv_n}, 7);
    chk(!rd_valid && !req_ready && !fl_rst_n, "R1", "valid/ready/flash reset in reset",
        {rd_valid, req_ready, fl_rst_n}, 0);
    chk(fl_we_n && fl_clk, "R3", "we and clk high", {fl_we_n, fl_clk}, 3);
    @(posedge clk); #1 rst = 0;
    wait_idle();
    send(20'h00123, 0, 0, 1);
    send(20'h00456, 0, 0, 0);
    send(20'h01000, 2, 0, 1);
    send(20'h00040, 3, 1, 0);
    send(20'h00042, 4, 1, 1);
    send(20'h00007, 1, 1, 0);
    wait_idle();
    @(posedge clk); #1 rst_req = 1;
    @(posedge clk); #1 rst_req = 0;
    repeat (2) @(negedge clk);
    chk(fl_rst_n == 1'b0, "R2", "flash reset driven after request", fl_rst_n, 0);
    wait_idle();
    send(20'h00001, 15, 1, 1);
    send(20'hFFFFE, 3, 1, 0);
    noise = 1;
    send(20'h00123, 0, 0, 1);
    for (int i = 0; i < 30; i++)
      send(AW'($urandom), int'($urandom % 6), 1'($urandom % 2), 1'($urandom % 2));
    noise = 0;
    repeat (5) @(negedge clk);
    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", "run did not complete", 0, 1);
      report();
      $finish;
    end
  end
endmodule